// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an on-chip request port and an external asynchronous static RAM of 32K one-byte locations. It takes one read or write at a time from a valid/ready port. It then drives the memory's active-low chip select, output enable and write enable, a 15-bit address and an 8-bit data bus. The data bus is split into an output byte, an output-enable line and an input byte. When no transaction is in flight, the memory is deselected: chip select is high and the controller's data drivers are off.

Two parameters set the timing: a speed grade (fast or slow) and the clock period in nanoseconds. Each nanosecond limit of the memory is turned into a whole number of clock cycles with a ceiling divide, and every strobe phase lasts exactly that number of cycles. Read results come back with a one-cycle valid pulse. A finished write gives a one-cycle done pulse. After every read, a turn-around gap covers the time the memory may keep driving its pins. During that gap the controller cannot enable its own drivers.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it: chip select, output enable and write enable are high, the data drivers are off, ready is high, and both the read-valid and write-done pulses are low.
- R2: Each limit converts to ceil(ns / CLK_NS) cycles, and to at least 1 for any nonzero limit. With the defaults (fast grade, 8 ns clock) the counts are:
  - read strobe: 7 cycles
  - turn-around: 3 cycles
  - write-enable pulse: 7 cycles
  - drive delay: 3 cycles
  - write tail: 0 cycles
- R3: A read holds chip select and output enable low, write enable high and the address stable for max(ceil(t_rc), ceil(t_oe)) cycles. The input byte is captured on the last of those edges.
- R4: Read-valid goes high for exactly one cycle, in the first cycle after chip select returns high. It carries the captured byte.
- R5: A write holds chip select and write enable low for max(ceil(t_wp), ceil(t_aw), ceil(t_whz) + ceil(t_dw)) cycles. Output enable stays high throughout the write.
- R6: Write data is driven starting ceil(t_whz) cycles after write enable falls and stops on the edge where write enable rises. While driven, it equals the requested byte.
- R7: When ceil(t_wc) exceeds the pulse length, the address is held with the memory deselected for the difference (the tail). Write-done is then a one-cycle pulse in the cycle after the tail.
- R8: Address and chip select do not change while write enable is low.
- R9: After a read, ready stays low for ceil(t_hz) turn-around cycles. The data drivers are never enabled while the memory may still be driving the bus.
- R10: Ready is low from acceptance until the transaction, including any tail or turn-around, is complete. Only one transaction is in flight.
- R11: Whenever ready is high, chip select is high and the data drivers are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| rsp_rvalid | output | 1 | One-cycle read result pulse |
| rsp_rdata | output | 8 | Read byte |
| rsp_wdone | output | 1 | One-cycle write completion pulse |
| mem_addr | output | 15 | Memory address bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Enables the controller's data drivers |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
Counting from the accepting edge, a read keeps its strobes low for 7 cycles. Its valid pulse is seen in the next cycle, and ready returns after 3 more turn-around cycles. A write drives its data from the 4th strobe cycle through the 7th, and its done pulse appears in the first cycle after write enable rises. The bench samples every output at the falling clock edge. It counts strobe, drive and gap cycles one by one and compares each count with its own ceiling arithmetic. Its memory model returns a wrong byte until the access time has elapsed. It also flags any driver overlap inside its release window, so a capture or drive that comes one cycle early shows up as a mismatch.

// File: rtl/sram_async_ctl_pkg.sv
package sram_async_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WRITE,
    ST_WTAIL
  } ctl_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // ceiling divide, never below one cycle for a nonzero limit
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    if (ns <= 0) return 0;
    return imax(1, (ns + clk_ns - 1) / clk_ns);
  endfunction

  function automatic int ns_rd_cycle(input bit fast);  return fast ? 55 : 70; endfunction
  function automatic int ns_oe_valid(input bit fast);  return fast ? 25 : 35; endfunction
  function automatic int ns_rd_release(input bit fast); return fast ? 20 : 30; endfunction
  function automatic int ns_wr_cycle(input bit fast);  return fast ? 55 : 70; endfunction
  function automatic int ns_we_width(input bit fast);  return fast ? 40 : 50; endfunction
  function automatic int ns_addr_to_end(input bit fast); return fast ? 45 : 60; endfunction
  function automatic int ns_data_setup(input bit fast); return fast ? 25 : 30; endfunction
  function automatic int ns_we_float(input bit fast);  return fast ? 20 : 25; endfunction

  function automatic int rd_cycles(input bit fast, input int clk_ns);
    return imax(ns_to_cyc(ns_rd_cycle(fast), clk_ns), ns_to_cyc(ns_oe_valid(fast), clk_ns));
  endfunction

  function automatic int turn_cycles(input bit fast, input int clk_ns);
    return ns_to_cyc(ns_rd_release(fast), clk_ns);
  endfunction

  function automatic int drive_delay(input bit fast, input int clk_ns);
    return ns_to_cyc(ns_we_float(fast), clk_ns);
  endfunction

  function automatic int pulse_cycles(input bit fast, input int clk_ns);
    return imax(imax(ns_to_cyc(ns_we_width(fast), clk_ns), ns_to_cyc(ns_addr_to_end(fast), clk_ns)),
                drive_delay(fast, clk_ns) + ns_to_cyc(ns_data_setup(fast), clk_ns));
  endfunction

  function automatic int tail_cycles(input bit fast, input int clk_ns);
    int wc;
    wc = ns_to_cyc(ns_wr_cycle(fast), clk_ns);
    return (wc > pulse_cycles(fast, clk_ns)) ? wc - pulse_cycles(fast, clk_ns) : 0;
  endfunction

endpackage

// File: rtl/sram_async_ctl_seq.sv
module sram_async_ctl_seq
  import sram_async_ctl_pkg::*;
#(
  parameter int RD_CYC    = 7,
  parameter int TURN_CYC  = 3,
  parameter int DRV_CYC   = 3,
  parameter int PULSE_CYC = 7,
  parameter int TAIL_CYC  = 0,
  parameter int CNT_W     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic ready,
  output logic accept,
  output logic rd_capture,
  output logic cs_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe,
  output logic rvalid,
  output logic wdone
);

  ctl_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] elapsed;
  logic             cnt_zero;

  assign ready      = (state == ST_IDLE);
  assign accept     = req_valid && ready;
  assign cnt_zero   = (cnt == '0);
  assign rd_capture = (state == ST_READ) && cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      elapsed <= '0;
      cs_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
      rvalid  <= 1'b0;
      wdone   <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      wdone  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cs_n <= 1'b0;
            if (req_write) begin
              we_n    <= 1'b0;
              elapsed <= CNT_W'(1);
              cnt     <= CNT_W'(PULSE_CYC - 1);
              state   <= ST_WRITE;
            end else begin
              oe_n  <= 1'b0;
              cnt   <= CNT_W'(RD_CYC - 1);
              state <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (cnt_zero) begin
            cs_n   <= 1'b1;
            oe_n   <= 1'b1;
            rvalid <= 1'b1;
            cnt    <= CNT_W'(TURN_CYC - 1);
            state  <= ST_TURN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TURN: begin
          if (cnt_zero) state <= ST_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        ST_WRITE: begin
          if (cnt_zero) begin
            we_n  <= 1'b1;
            cs_n  <= 1'b1;
            dq_oe <= 1'b0;
            if (TAIL_CYC > 0) begin
              cnt   <= CNT_W'(TAIL_CYC - 1);
              state <= ST_WTAIL;
            end else begin
              wdone <= 1'b1;
              state <= ST_IDLE;
            end
          end else begin
            cnt     <= cnt - 1'b1;
            elapsed <= elapsed + 1'b1;
            if (elapsed >= CNT_W'(DRV_CYC)) dq_oe <= 1'b1;
          end
        end
        ST_WTAIL: begin
          if (cnt_zero) begin
            wdone <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_async_ctl_dp.sv
module sram_async_ctl_dp #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_capture) rdata_q <= dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_async_ctl_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 8,
  parameter bit SPEED_FAST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_rvalid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_wdone,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC    = rd_cycles(SPEED_FAST, CLK_NS);
  localparam int TURN_CYC  = turn_cycles(SPEED_FAST, CLK_NS);
  localparam int DRV_CYC   = drive_delay(SPEED_FAST, CLK_NS);
  localparam int PULSE_CYC = pulse_cycles(SPEED_FAST, CLK_NS);
  localparam int TAIL_CYC  = tail_cycles(SPEED_FAST, CLK_NS);
  localparam int MAX_CYC   = imax(imax(RD_CYC, PULSE_CYC), imax(TURN_CYC, TAIL_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  logic accept;
  logic rd_capture;

  sram_async_ctl_seq #(
    .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC), .DRV_CYC(DRV_CYC),
    .PULSE_CYC(PULSE_CYC), .TAIL_CYC(TAIL_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .ready(req_ready), .accept(accept), .rd_capture(rd_capture),
    .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_oe(mem_dq_oe),
    .rvalid(rsp_rvalid), .wdone(rsp_wdone)
  );

  sram_async_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .rd_capture(rd_capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(mem_dq_in),
    .addr_q(mem_addr), .wdata_q(mem_dq_out), .rdata_q(rsp_rdata)
  );

endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk #(
  parameter int ADDR_W   = 15,
  parameter int TURN_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_rvalid,
  input logic              rsp_wdone,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic              rd_capture
);

  // cycles since output enable was last seen low, saturating
  logic [7:0] since_oe;
  always_ff @(posedge clk) begin
    if (!rst_n)             since_oe <= 8'hFF;
    else if (!mem_oe_n)     since_oe <= '0;
    else if (since_oe != 8'hFF) since_oe <= since_oe + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe);
  p_capture_strobed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> !mem_cs_n && !mem_oe_n && mem_we_n);
  p_read_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));
  p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n) rsp_rvalid |=> !rsp_rvalid);
  p_oe_high_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> mem_oe_n);
  p_drive_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> !mem_we_n && !mem_cs_n);
  p_wdone_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) rsp_wdone |=> !rsp_wdone);
  p_write_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr) && !mem_cs_n);
  p_turnaround_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> since_oe >= 8'(TURN_CYC));
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n) !mem_cs_n |-> !req_ready);
  p_idle_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n && !mem_dq_oe);

endmodule

bind sram_async_ctl sram_async_ctl_chk #(.ADDR_W(ADDR_W), .TURN_CYC(TURN_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_rvalid(rsp_rvalid),
  .rsp_wdone(rsp_wdone), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe),
  .rd_capture(rd_capture)
);

// File: tb/sram_async_ctl_bench.sv
module sram_async_ctl_bench;

  localparam int CLK = 8;

  // bench-side restatement of the conversion rule
  function automatic int up(input int ns);
    int c;
    c = ns / CLK;
    if (c * CLK < ns) c = c + 1;
    if (ns > 0 && c < 1) c = 1;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    if (a > b) return a;
    return b;
  endfunction

  localparam int E_RD    = 7;
  localparam int E_TURN  = 3;
  localparam int E_DRV   = 3;
  localparam int E_PULSE = 7;
  localparam int E_TAIL  = 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_rvalid, rsp_wdone;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sram_async_ctl u_sram_async_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata), .rsp_wdone(rsp_wdone),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory model and expected contents
  byte unsigned model_mem[int];
  byte unsigned exp_mem[int];
  function automatic byte unsigned init_val(input int a);
    return byte'(a[7:0] ^ 8'h3C);
  endfunction
  function automatic byte unsigned model_rd(input int a);
    if (model_mem.exists(a)) return model_mem[a];
    return init_val(a);
  endfunction
  function automatic byte unsigned exp_rd(input int a);
    if (exp_mem.exists(a)) return exp_mem[a];
    return init_val(a);
  endfunction

  int   rd_cnt = 0;
  int   rel_cnt = 0;
  bit   we_prev = 1'b0;
  logic [7:0] pend = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      // contention: controller drives while memory may still drive (R9)
      if (mem_dq_oe && (rd_cnt > 0 || rel_cnt > 0))
        chk(1'b0, "R9 bus contention", 1, 0);
      if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
        rd_cnt = rd_cnt + 1;
        rel_cnt = up(20);
      end else begin
        rd_cnt = 0;
        if (rel_cnt > 0) rel_cnt = rel_cnt - 1;
      end
      mem_dq_in <= (rd_cnt >= mx(up(55), up(25))) ? model_rd(int'(mem_addr)) : 8'hEE;
      if (!mem_cs_n && !mem_we_n && mem_dq_oe) pend = mem_dq_out;
      if (we_prev && mem_we_n) model_mem[int'(mem_addr)] = pend;
      we_prev = !mem_we_n;
    end
  end

  task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = $urandom; req_wdata = $urandom;
  endtask

  task automatic do_read(input logic [14:0] a);
    int n;
    byte unsigned e;
    e = exp_rd(int'(a));
    issue(1'b0, a, 8'h00);
    n = 0;
    while (!mem_cs_n && n < 100) begin
      n++;
      if (mem_oe_n || !mem_we_n || mem_addr != a || req_ready || mem_dq_oe)
        chk(1'b0, "R3 R10 read strobes", {mem_oe_n, mem_we_n, req_ready}, 3'b010);
      @(negedge clk);
    end
    chk(n == E_RD, "R2 R3 read strobe cycles", n, E_RD);
    chk(rsp_rvalid == 1'b1, "R4 read valid", rsp_rvalid, 1);
    chk(rsp_rdata == e, "R4 read data", rsp_rdata, e);
    n = 0;
    while (!req_ready && n < 100) begin
      n++;
      if (mem_dq_oe || !mem_cs_n) chk(1'b0, "R9 turn-around idle bus", mem_dq_oe, 0);
      @(negedge clk);
      if (n == 1) chk(rsp_rvalid == 1'b0, "R4 valid one cycle", rsp_rvalid, 0);
    end
    chk(n == E_TURN, "R9 turn-around cycles", n, E_TURN);
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d);
    int n, first, drv;
    issue(1'b1, a, d);
    exp_mem[int'(a)] = d;
    n = 0; first = 0; drv = 0;
    while (!mem_cs_n && n < 100) begin
      n++;
      if (mem_we_n || !mem_oe_n || mem_addr != a || req_ready)
        chk(1'b0, "R5 R8 R10 write strobes", {mem_we_n, mem_oe_n, req_ready}, 3'b010);
      if (mem_dq_oe) begin
        drv++;
        if (first == 0) first = n;
        if (mem_dq_out != d) chk(1'b0, "R6 write data value", mem_dq_out, d);
      end
      @(negedge clk);
    end
    chk(n == E_PULSE, "R2 R5 write pulse cycles", n, E_PULSE);
    chk(first == E_DRV + 1, "R6 drive start", first, E_DRV + 1);
    chk(drv == E_PULSE - E_DRV && drv >= up(25), "R6 drive length", drv, E_PULSE - E_DRV);
    chk(!mem_dq_oe, "R6 drive off at write end", mem_dq_oe, 0);
    n = 0;
    while (!rsp_wdone && n < 100) begin
      n++;
      if (mem_addr != a) chk(1'b0, "R7 tail address hold", mem_addr, a);
      @(negedge clk);
    end
    chk(n == E_TAIL, "R7 tail cycles", n, E_TAIL);
    chk(req_ready == 1'b1, "R10 ready at done", req_ready, 1);
    @(negedge clk);
    chk(rsp_wdone == 1'b0, "R7 done one cycle", rsp_wdone, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [14:0] pool [8];
    void'($urandom(32'd20240611));
    // the bench restates the default counts from the ns limits (R2)
    chk(E_RD == mx(up(55), up(25)), "R2 read count", mx(up(55), up(25)), E_RD);
    chk(E_PULSE == mx(mx(up(40), up(45)), up(20) + up(25)), "R2 pulse count",
        mx(mx(up(40), up(45)), up(20) + up(25)), E_PULSE);
    repeat (3) @(negedge clk);
    chk({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe} == 4'b1110, "R1 strobes in reset",
        {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_rvalid && !rsp_wdone && mem_cs_n, "R1 after reset",
        {req_ready, rsp_rvalid, rsp_wdone, mem_cs_n}, 4'b1001);

    // directed corners
    do_read(15'h0000);
    do_write(15'h7FFF, 8'hA5);
    do_read(15'h7FFF);
    do_write(15'h0000, 8'h5A);   // write straight after a read: turn-around
    do_write(15'h0001, 8'hFF);   // back-to-back writes
    do_read(15'h0000);
    do_read(15'h0001);
    repeat (4) @(negedge clk);
    chk(mem_cs_n && !mem_dq_oe && req_ready, "R11 idle deselect",
        {mem_cs_n, mem_dq_oe}, 2'b10);

    for (int i = 0; i < 8; i++) pool[i] = 15'($urandom);
    for (int i = 0; i < 60; i++) begin
      logic [14:0] a;
      a = ($urandom % 2) ? pool[$urandom % 8] : 15'($urandom);
      if ($urandom % 2) do_write(a, 8'($urandom));
      else              do_read(a);
      repeat ($urandom % 3) begin
        @(negedge clk);
        chk(mem_cs_n && !mem_dq_oe, "R11 idle between requests", mem_cs_n, 1);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule